// File: doc/BRIEF.md
# Per-ID Write-Burst Ordering Monitor

This block sits beside an interconnect and watches two write-address ports: the one where a master issues bursts and the one where a slave receives them. Each burst accepted on the master side is stored in a small queue selected by its transaction ID. When a burst with that ID is accepted on the slave side, the oldest stored burst of that ID is removed and compared field by field. Bursts sharing an ID must therefore reach the slave in the order the master issued them. Bursts with different IDs may overtake each other freely.

The monitor also watches the master-side write-response channel. A compared burst stays pending until the master accepts an OKAY response for its ID. Only then does it count as done. Error conditions raise sticky flags, and counters track matches, mismatches and completions. An idle output lets a test confirm at its end that nothing is left in flight.

Top module: `awo_order_checker`

## Requirements
- R1: A burst is captured on a port only in a cycle where that port's valid and ready are both high. Valid without ready changes no output.
- R2: One queue of DEPTH entries is kept per ID. A slave-side burst is compared with the oldest entry of its own ID's queue. IDs are independent, so bursts with different IDs may arrive in any order. Each equal comparison adds one to `match_count` one cycle after the handshake.
- R3: A comparison covers the start address, length (8 bits), size (3 bits) and burst type (2 bits), and the ID through the choice of queue. Any difference sets the sticky `err_mismatch` flag and adds one to `mismatch_count`. The entry is consumed either way.
- R4: A slave-side burst whose ID queue is empty sets the sticky `err_unexpected` flag and touches no queue.
- R5: A master-side burst whose ID queue is full, and which is not popped in the same cycle, sets the sticky `err_overflow` flag. The burst is dropped, and the queue keeps its older entries in order.
- R6: A push and a pop on the same full ID queue in one cycle both take effect. No overflow is flagged and no entry is lost.
- R7: Each compared burst waits for a response on its ID. A response handshake with code 2'b00 (OKAY) on an ID that has a waiting burst adds one to `done_count`. Any other code, or a response on an ID with nothing waiting, sets the sticky `err_resp` flag. A non-OKAY code still retires a waiting burst.
- R8: `idle` is high exactly when every ID queue is empty and no compared burst is waiting for its response.
- R9: After reset, all flags and counters are zero and `idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_aw_valid | input | 1 | Master-side address valid |
| mst_aw_ready | input | 1 | Master-side address ready |
| mst_aw_id | input | ID_W | Master-side transaction ID |
| mst_aw_addr | input | ADDR_W | Master-side start address |
| mst_aw_len | input | 8 | Master-side burst length |
| mst_aw_size | input | 3 | Master-side burst size |
| mst_aw_burst | input | 2 | Master-side burst type |
| slv_aw_valid | input | 1 | Slave-side address valid |
| slv_aw_ready | input | 1 | Slave-side address ready |
| slv_aw_id | input | ID_W | Slave-side transaction ID |
| slv_aw_addr | input | ADDR_W | Slave-side start address |
| slv_aw_len | input | 8 | Slave-side burst length |
| slv_aw_size | input | 3 | Slave-side burst size |
| slv_aw_burst | input | 2 | Slave-side burst type |
| mst_b_valid | input | 1 | Master-side response valid |
| mst_b_ready | input | 1 | Master-side response ready |
| mst_b_id | input | ID_W | Response ID |
| mst_b_resp | input | 2 | Response code |
| err_unexpected | output | 1 | Sticky: slave burst with no queued entry |
| err_overflow | output | 1 | Sticky: push into a full queue |
| err_mismatch | output | 1 | Sticky: field difference on compare |
| err_resp | output | 1 | Sticky: bad or orphan response |
| match_count | output | CNT_W | Equal comparisons |
| mismatch_count | output | CNT_W | Unequal comparisons |
| done_count | output | CNT_W | Bursts retired with OKAY |
| idle | output | 1 | Nothing queued or waiting |

## Verification
A single cycle can carry three events at once: a master push, a slave pop and a response retirement. The cases that matter most are a push and a pop landing on the same ID queue when it is full, and a response landing on the same ID as a pop. The bench fills one queue to DEPTH and then pushes and pops that ID in the same cycle. It also lets the random phase produce these collisions freely. A bench-side model applies the response first, then the pop, then the push. After that edge it judges the flags, all counters and `idle` against the model, then drains the queue to show that every entry survived in order.

// File: rtl/awo_pkg.sv
package awo_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_code_e;

  function automatic logic resp_is_okay(input logic [1:0] code);
    return code == RESP_OKAY;
  endfunction
endpackage

// File: rtl/awo_id_queue.sv
module awo_id_queue #(
  parameter int W     = 29,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;
  logic             wr_en, rd_en;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign rd_en = pop && !empty;
  assign wr_en = push && (!full || rd_en);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (rd_en) rd_ptr <= ptr_next(rd_ptr);
      if (wr_en) wr_ptr <= ptr_next(wr_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/awo_resp_track.sv
module awo_resp_track #(
  parameter int ID_W   = 2,
  parameter int PEND_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [(1<<ID_W)-1:0] inc_vec,
  input  logic                 b_hs,
  input  logic [ID_W-1:0]      b_id,
  input  logic                 b_okay,
  output logic                 done_ev,
  output logic                 resp_err_ev,
  output logic                 all_clear
);
  localparam int NUM_ID = 1 << ID_W;
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [NUM_ID-1:0] nz_vec;

  for (genvar g = 0; g < NUM_ID; g++) begin : g_pend
    logic [PEND_W-1:0] pend;
    logic dec, inc;
    assign dec = b_hs && (b_id == ID_W'(g)) && (pend != '0);
    assign inc = inc_vec[g] && (pend != PEND_MAX || dec);
    assign nz_vec[g] = (pend != '0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else if (inc && !dec) pend <= pend + PEND_W'(1);
      else if (dec && !inc) pend <= pend - PEND_W'(1);
    end
  end

  assign done_ev     = b_hs && nz_vec[b_id] && b_okay;
  assign resp_err_ev = b_hs && (!nz_vec[b_id] || !b_okay);
  assign all_clear   = ~|nz_vec;
endmodule

// File: rtl/awo_order_checker.sv
module awo_order_checker #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 16,
  parameter int PEND_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mst_aw_valid,
  input  logic              mst_aw_ready,
  input  logic [ID_W-1:0]   mst_aw_id,
  input  logic [ADDR_W-1:0] mst_aw_addr,
  input  logic [7:0]        mst_aw_len,
  input  logic [2:0]        mst_aw_size,
  input  logic [1:0]        mst_aw_burst,
  input  logic              slv_aw_valid,
  input  logic              slv_aw_ready,
  input  logic [ID_W-1:0]   slv_aw_id,
  input  logic [ADDR_W-1:0] slv_aw_addr,
  input  logic [7:0]        slv_aw_len,
  input  logic [2:0]        slv_aw_size,
  input  logic [1:0]        slv_aw_burst,
  input  logic              mst_b_valid,
  input  logic              mst_b_ready,
  input  logic [ID_W-1:0]   mst_b_id,
  input  logic [1:0]        mst_b_resp,
  output logic              err_unexpected,
  output logic              err_overflow,
  output logic              err_mismatch,
  output logic              err_resp,
  output logic [CNT_W-1:0]  match_count,
  output logic [CNT_W-1:0]  mismatch_count,
  output logic [CNT_W-1:0]  done_count,
  output logic              idle
);
  localparam int NUM_ID = 1 << ID_W;
  localparam int ENT_W  = ADDR_W + 13;

  function automatic logic [ENT_W-1:0] pack_aw(input logic [ADDR_W-1:0] a,
                                               input logic [7:0] l,
                                               input logic [2:0] s,
                                               input logic [1:0] b);
    return {b, s, l, a};
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return (c == '1) ? c : c + CNT_W'(1);
  endfunction

  logic mst_hs, slv_hs, b_hs;
  assign mst_hs = mst_aw_valid && mst_aw_ready;
  assign slv_hs = slv_aw_valid && slv_aw_ready;
  assign b_hs   = mst_b_valid && mst_b_ready;

  logic [ENT_W-1:0] mst_ent, slv_ent, head_sel;
  assign mst_ent = pack_aw(mst_aw_addr, mst_aw_len, mst_aw_size, mst_aw_burst);
  assign slv_ent = pack_aw(slv_aw_addr, slv_aw_len, slv_aw_size, slv_aw_burst);

  logic [NUM_ID-1:0] push_vec, pop_vec, empty_vec, full_vec;
  logic [ENT_W-1:0]  head_arr [NUM_ID];

  for (genvar g = 0; g < NUM_ID; g++) begin : g_q
    assign push_vec[g] = mst_hs && (mst_aw_id == ID_W'(g));
    assign pop_vec[g]  = slv_hs && (slv_aw_id == ID_W'(g)) && !empty_vec[g];
    awo_id_queue #(.W(ENT_W), .DEPTH(DEPTH)) q_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_vec[g]),
      .pop   (pop_vec[g]),
      .din   (mst_ent),
      .dout  (head_arr[g]),
      .empty (empty_vec[g]),
      .full  (full_vec[g])
    );
  end

  logic slv_empty, unexp_ev, cmp_ev, mism_ev, match_ev, ovf_ev;
  assign head_sel  = head_arr[slv_aw_id];
  assign slv_empty = empty_vec[slv_aw_id];
  assign unexp_ev  = slv_hs && slv_empty;
  assign cmp_ev    = slv_hs && !slv_empty;
  assign mism_ev   = cmp_ev && (head_sel != slv_ent);
  assign match_ev  = cmp_ev && (head_sel == slv_ent);
  assign ovf_ev    = |(push_vec & full_vec & ~pop_vec);

  logic done_ev, resp_err_ev, pend_clear;
  awo_resp_track #(.ID_W(ID_W), .PEND_W(PEND_W)) rt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_vec     (pop_vec),
    .b_hs        (b_hs),
    .b_id        (mst_b_id),
    .b_okay      (awo_pkg::resp_is_okay(mst_b_resp)),
    .done_ev     (done_ev),
    .resp_err_ev (resp_err_ev),
    .all_clear   (pend_clear)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_unexpected <= 1'b0;
      err_overflow   <= 1'b0;
      err_mismatch   <= 1'b0;
      err_resp       <= 1'b0;
      match_count    <= '0;
      mismatch_count <= '0;
      done_count     <= '0;
    end else begin
      if (unexp_ev)    err_unexpected <= 1'b1;
      if (ovf_ev)      err_overflow   <= 1'b1;
      if (mism_ev)     err_mismatch   <= 1'b1;
      if (resp_err_ev) err_resp       <= 1'b1;
      if (match_ev)    match_count    <= bump(match_count);
      if (mism_ev)     mismatch_count <= bump(mismatch_count);
      if (done_ev)     done_count     <= bump(done_count);
    end
  end

  assign idle = (&empty_vec) && pend_clear;
endmodule

// File: rtl/awo_order_sva.sv
module awo_order_sva #(
  parameter int NUM_ID = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mst_aw_valid,
  input logic              mst_aw_ready,
  input logic              slv_hs,
  input logic              b_hs,
  input logic [NUM_ID-1:0] push_vec,
  input logic [NUM_ID-1:0] pop_vec,
  input logic              unexp_ev,
  input logic              ovf_ev,
  input logic              cmp_ev,
  input logic              err_unexpected,
  input logic              err_overflow,
  input logic              err_resp,
  input logic [CNT_W-1:0]  match_count,
  input logic [CNT_W-1:0]  mismatch_count,
  input logic              idle
);
  // R1
  push_needs_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|push_vec) |-> (mst_aw_valid && mst_aw_ready && $onehot0(push_vec)));
  // R2
  counts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_ev |=> ($stable(match_count) && $stable(mismatch_count)));
  // R4
  unexp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unexp_ev |=> err_unexpected);
  // R4
  unexp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_unexpected |=> err_unexpected);
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> err_overflow);
  // R6
  single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop_vec) && ((|pop_vec) == cmp_ev));
  // R7
  resp_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_resp) |-> $past(b_hs));
  // R8
  idle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && slv_hs) |-> unexp_ev);
endmodule

bind awo_order_checker awo_order_sva #(.NUM_ID(NUM_ID), .CNT_W(CNT_W)) sva_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .mst_aw_valid   (mst_aw_valid),
  .mst_aw_ready   (mst_aw_ready),
  .slv_hs         (slv_hs),
  .b_hs           (b_hs),
  .push_vec       (push_vec),
  .pop_vec        (pop_vec),
  .unexp_ev       (unexp_ev),
  .ovf_ev         (ovf_ev),
  .cmp_ev         (cmp_ev),
  .err_unexpected (err_unexpected),
  .err_overflow   (err_overflow),
  .err_resp       (err_resp),
  .match_count    (match_count),
  .mismatch_count (mismatch_count),
  .idle           (idle)
);

// File: tb/awo_order_checker_tb.sv
module awo_order_checker_tb_top;
  localparam int NID = 4;
  localparam int DEP = 4;
  localparam int PMAX = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic mv = 0, mr = 0, sv = 0, sr = 0, bv = 0, br = 0;
  logic [1:0] mid = 0, sid = 0, bid = 0, bresp = 0;
  logic [15:0] maddr = 0, saddr = 0;
  logic [7:0] mlen = 0, slen = 0;
  logic [2:0] msz = 0, ssz = 0;
  logic [1:0] mbu = 0, sbu = 0;
  logic eu, eo, em, er, idl;
  logic [15:0] mc, mmc, dc;

  awo_order_checker dut_i (
    .clk(clk), .rst_n(rst_n),
    .mst_aw_valid(mv), .mst_aw_ready(mr), .mst_aw_id(mid), .mst_aw_addr(maddr),
    .mst_aw_len(mlen), .mst_aw_size(msz), .mst_aw_burst(mbu),
    .slv_aw_valid(sv), .slv_aw_ready(sr), .slv_aw_id(sid), .slv_aw_addr(saddr),
    .slv_aw_len(slen), .slv_aw_size(ssz), .slv_aw_burst(sbu),
    .mst_b_valid(bv), .mst_b_ready(br), .mst_b_id(bid), .mst_b_resp(bresp),
    .err_unexpected(eu), .err_overflow(eo), .err_mismatch(em), .err_resp(er),
    .match_count(mc), .mismatch_count(mmc), .done_count(dc), .idle(idl)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [28:0] mq [NID][DEP];
  int qn [NID];
  int pend [NID];
  logic x_eu, x_eo, x_em, x_er;
  int x_mc, x_mmc, x_dc;

  function automatic logic [28:0] key(input logic [15:0] a, input logic [7:0] l,
                                      input logic [2:0] s, input logic [1:0] b);
    return {a, l, s, b};
  endfunction

  function automatic logic exp_idle();
    for (int i = 0; i < NID; i++) if (qn[i] != 0 || pend[i] != 0) return 0;
    return 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NID; i++) begin qn[i] = 0; pend[i] = 0; end
    x_eu = 0; x_eo = 0; x_em = 0; x_er = 0; x_mc = 0; x_mmc = 0; x_dc = 0;
  endtask

  task automatic model_step();
    if (bv && br) begin
      if (pend[bid] > 0 && bresp == 2'b00) begin pend[bid]--; x_dc++; end
      else begin if (pend[bid] > 0) pend[bid]--; x_er = 1; end
    end
    if (sv && sr) begin
      if (qn[sid] == 0) x_eu = 1;
      else begin
        if (mq[sid][0] == key(saddr, slen, ssz, sbu)) x_mc++;
        else begin x_mmc++; x_em = 1; end
        for (int k = 0; k < DEP - 1; k++) mq[sid][k] = mq[sid][k+1];
        qn[sid]--;
        if (pend[sid] < PMAX) pend[sid]++;
      end
    end
    if (mv && mr) begin
      if (qn[mid] == DEP) x_eo = 1;
      else begin mq[mid][qn[mid]] = key(maddr, mlen, msz, mbu); qn[mid]++; end
    end
  endtask

  task automatic check_all();
    chk("R4 err_unexpected", eu, x_eu);
    chk("R5 err_overflow", eo, x_eo);
    chk("R3 err_mismatch", em, x_em);
    chk("R7 err_resp", er, x_er);
    chk("R2 match_count", mc, x_mc);
    chk("R3 mismatch_count", mmc, x_mmc);
    chk("R7 done_count", dc, x_dc);
    chk("R8 idle", idl, exp_idle());
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #1;
    check_all();
  endtask

  task automatic quiet();
    mv = 0; mr = 0; sv = 0; sr = 0; bv = 0; br = 0;
  endtask

  task automatic do_reset();
    quiet();
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9 reset flags", {eu, eo, em, er}, 0);
    chk("R9 reset counts", mc + mmc + dc, 0);
    chk("R9 reset idle", idl, 1);
    rst_n = 1;
  endtask

  task automatic set_m(input logic [1:0] i, input logic [15:0] a);
    mv = 1; mr = 1; mid = i; maddr = a; mlen = a[7:0]; msz = a[2:0]; mbu = a[4:3];
  endtask

  task automatic set_s(input logic [1:0] i, input logic [15:0] a);
    sv = 1; sr = 1; sid = i; saddr = a; slen = a[7:0]; ssz = a[2:0]; sbu = a[4:3];
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    #1;
    // R1: valid without ready, ready without valid
    mv = 1; mr = 0; mid = 0; maddr = 16'h10; sv = 1; sr = 0; sid = 0;
    cyc();
    mv = 0; mr = 1; sv = 0; sr = 1;
    cyc();
    chk("R1 no capture idle", idl, 1);
    quiet();
    // R5: five pushes on ID 1, then drain four, then one extra (R4)
    for (int k = 0; k < 5; k++) begin set_m(1, 16'h100 + 16'(k)); cyc(); end
    quiet();
    chk("R5 overflow flagged", eo, 1);
    for (int k = 0; k < 4; k++) begin set_s(1, 16'h100 + 16'(k)); cyc(); end
    chk("R5 older entries kept", mc, 4);
    set_s(1, 16'h104); cyc();
    chk("R4 empty queue pop", eu, 1);
    quiet();
    do_reset();
    #1;
    // R6: fill ID 2, then push and pop together
    for (int k = 0; k < DEP; k++) begin set_m(2, 16'h200 + 16'(k)); cyc(); end
    set_m(2, 16'h2AA); set_s(2, 16'h200); cyc();
    quiet();
    chk("R6 no overflow on push+pop", eo, 0);
    for (int k = 1; k < DEP; k++) begin set_s(2, 16'h200 + 16'(k)); cyc(); end
    set_s(2, 16'h2AA); cyc();
    quiet();
    chk("R6 all five matched", mc, 5);
    // R2: cross-ID order freedom, R3 mismatch
    set_m(0, 16'h30); cyc(); set_m(3, 16'h33); cyc(); quiet();
    set_s(3, 16'h33); cyc(); set_s(0, 16'h31); cyc(); quiet();
    chk("R2 cross-ID match", mc, 6);
    chk("R3 addr mismatch counted", mmc, 1);
    // R7: error response then OKAY responses on ID 2
    bv = 1; br = 1; bid = 2; bresp = 2'b10; cyc();
    chk("R7 non-OKAY flagged", er, 1);
    bresp = 2'b00; cyc();
    chk("R7 OKAY done", dc, 1);
    quiet();
    do_reset();
    #1;
    // R7: orphan response
    bv = 1; br = 1; bid = 1; bresp = 2'b00; cyc(); quiet();
    chk("R7 orphan response", er, 1);
    do_reset();
    #1;
    // random phase (R1..R8)
    for (int n = 0; n < 4000; n++) begin
      int nz;
      quiet();
      mid = 2'($urandom_range(0, NID - 1));
      mv = ($urandom_range(0, 9) < 5) && (qn[mid] < DEP || $urandom_range(0, 19) == 0);
      mr = $urandom_range(0, 9) < 7;
      maddr = 16'($urandom); mlen = 8'($urandom); msz = 3'($urandom); mbu = 2'($urandom);
      nz = 0;
      for (int i = 0; i < NID; i++) if (qn[i] > 0) nz++;
      if (nz > 0 && $urandom_range(0, 9) < 6) begin
        int pick = $urandom_range(0, nz - 1);
        for (int i = 0; i < NID; i++) if (qn[i] > 0) begin
          if (pick == 0) sid = 2'(i);
          pick--;
        end
        {saddr, slen, ssz, sbu} = mq[sid][0];
        if ($urandom_range(0, 15) == 0) saddr = saddr ^ 16'h1;
        sv = 1; sr = $urandom_range(0, 9) < 7;
      end else if ($urandom_range(0, 49) == 0) begin
        sid = 2'($urandom); sv = 1; sr = 1;
        saddr = 16'($urandom); slen = 0; ssz = 0; sbu = 0;
      end
      bid = 2'($urandom_range(0, NID - 1));
      bv = (pend[bid] > 0) ? ($urandom_range(0, 9) < 8) : ($urandom_range(0, 99) == 0);
      br = $urandom_range(0, 9) < 8;
      bresp = ($urandom_range(0, 19) == 0) ? 2'b01 : 2'b00;
      cyc();
    end
    quiet();
    // drain and final idle check (R8)
    for (int i = 0; i < NID; i++) begin
      while (qn[i] > 0) begin
        {saddr, slen, ssz, sbu} = mq[i][0];
        sv = 1; sr = 1; sid = 2'(i); cyc();
      end
      quiet();
      while (pend[i] > 0) begin bv = 1; br = 1; bid = 2'(i); bresp = 0; cyc(); end
      quiet();
    end
    cyc();
    chk("R8 idle after drain", idl, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule